// File: doc/BRIEF.md
# Partitioned Coarse-Fine Vector Rotator

This block turns a two's complement vector (I, Q) counter-clockwise by an unsigned angle word in which a full turn equals 2^ANG_W. The angle word is split into two fields. The upper HI_W bits select a coarse angle. A table computed at elaboration time holds the cosine and sine of that angle, and the block applies the coarse rotation in one complex multiply. The lower ANG_W-HI_W bits form a small residual angle. That residual is at most one coarse step, because its upper bits are always zero. A first-order multiply-add applies it with no further table: the cosine is taken as one and the sine as the angle in radians.

Work moves through three registered stages: table read, coarse multiply, fine correction. A valid bit travels with each sample, and a new sample can enter on every clock. The final values are rounded to the output width and clamp at the representable limits. The block suits mixers and frequency shifters that need a short, fixed latency and can accept the small gain error of the first-order fine step.

Top module: `rot_cf_top`

## Requirements
- R1: A sample presented with `in_vld` high at a rising edge appears with `out_vld` high exactly three rising edges later. `out_vld` is low in every cycle that has no such sample.
- R2: While `rst` is high (synchronous, active high), `out_vld`, `out_i` and `out_q` are cleared at each edge. Samples that were in flight when reset arrived never appear.
- R3: When the residual field (bits ANG_W-HI_W-1..0) is zero, the output is the input rotated by hi·2π/2^HI_W, where hi is the field in bits ANG_W-1..ANG_W-HI_W. The result is within 1 LSB of the exact rotation.
- R4: For any angle, each output is within 2 LSB of In − Qn·θ (I lane) and Qn + In·θ (Q lane). Here (In, Qn) is the exact coarse rotation of the input and θ = lo·2π/2^ANG_W radians, with lo being the residual field.
- R5: Angle word 0 returns the input vector unchanged, bit for bit.
- R6: Results beyond the output range clamp to 2^(DAT_W-1)−1 or −2^(DAT_W-1). They never wrap.
- R7: Samples may be presented on consecutive cycles. Each one produces its own result, and results leave in the order the samples arrived.
- R8: While `out_vld` is low, `out_i` and `out_q` keep the values of the last result.
- R9: Quarter-turn angles are exact, apart from the clamping in R6. Angle 2^(ANG_W-2) gives (−Q, I), 2^(ANG_W-1) gives (−I, −Q), and 3·2^(ANG_W-2) gives (Q, −I).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Qualifies the angle and vector inputs for this cycle |
| in_ang | input | ANG_W | Unsigned rotation angle, full turn = 2^ANG_W, counter-clockwise |
| in_i | input | DAT_W | In-phase input coordinate, two's complement |
| in_q | input | DAT_W | Quadrature input coordinate, two's complement |
| out_vld | output | 1 | Marks a new rotated result on the outputs |
| out_i | output | DAT_W | Rotated in-phase coordinate, two's complement |
| out_q | output | DAT_W | Rotated quadrature coordinate, two's complement |

## Verification
When samples stream back to back, the coarse table lookup for the newest sample happens in the same cycle as the fine correction and output clamping of the sample two places earlier. The bench provokes this by walking a vector table on consecutive clocks. The table places a clamping half-turn next to quarter turns and to angles with large residuals. Each output is judged against the value the bench computes for that same sample alone, so a result that leaks into a neighbour, or arrives out of order, shows up as a mismatch.

// File: rtl/rot_cf_pkg.sv
package rot_cf_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // nearest integer, halves away from zero
   function automatic int round_near(input real x);
      if (x >= 0.0) return $rtoi(x + 0.5);
      return -$rtoi(-x + 0.5);
   endfunction

   // fixed-point cosine or sine of step idx out of 2^steps_log2 per turn
   function automatic int trig_coef(input int idx, input int steps_log2,
                                    input int frac, input bit want_sin);
      real a;
      real r;
      a = TWO_PI * real'(idx) / (2.0 ** steps_log2);
      r = want_sin ? $sin(a) : $cos(a);
      return round_near(r * (2.0 ** frac));
   endfunction

   // 2*pi scaled by 2^frac
   function automatic int turn_scale(input int frac);
      return round_near(TWO_PI * (2.0 ** frac));
   endfunction

endpackage

// File: rtl/rot_coarse_lut.sv
module rot_coarse_lut #(
   parameter int ANG_W  = 12,
   parameter int HI_W   = 6,
   parameter int DAT_W  = 12,
   parameter int CF     = 14,
   parameter int COEF_W = 16,
   parameter int RF     = 16,
   parameter int RAD_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic [ANG_W-1:0]         in_ang,
   input  logic signed [DAT_W-1:0]  in_i,
   input  logic signed [DAT_W-1:0]  in_q,
   output logic                     s1_vld,
   output logic signed [DAT_W-1:0]  s1_vec [2],
   output logic signed [COEF_W-1:0] s1_cos,
   output logic signed [COEF_W-1:0] s1_sin,
   output logic [RAD_W-1:0]         s1_rad
);
   localparam int TAB_N = 1 << HI_W;
   localparam int LO_W  = ANG_W - HI_W;
   localparam int PW    = LO_W + RF + 4;
   localparam int RAD_K = rot_cf_pkg::turn_scale(RF);

   logic signed [COEF_W-1:0] cos_tab [TAB_N];
   logic signed [COEF_W-1:0] sin_tab [TAB_N];

   for (genvar g = 0; g < TAB_N; g++) begin : g_tab
      localparam int CV = rot_cf_pkg::trig_coef(g, HI_W, CF, 1'b0);
      localparam int SV = rot_cf_pkg::trig_coef(g, HI_W, CF, 1'b1);
      assign cos_tab[g] = COEF_W'(CV);
      assign sin_tab[g] = COEF_W'(SV);
   end

   logic [HI_W-1:0] hi_idx;
   logic [LO_W-1:0] lo_bits;
   logic [PW-1:0]   rad_prod;

   assign hi_idx   = in_ang[ANG_W-1 -: HI_W];
   assign lo_bits  = in_ang[LO_W-1:0];
   // residual in radians with RF fraction bits, rounded
   assign rad_prod = PW'(lo_bits) * PW'(RAD_K) + (PW'(1) << (ANG_W - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld    <= 1'b0;
         s1_vec[0] <= '0;
         s1_vec[1] <= '0;
         s1_cos    <= '0;
         s1_sin    <= '0;
         s1_rad    <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_vec[0] <= in_i;
            s1_vec[1] <= in_q;
            s1_cos    <= cos_tab[hi_idx];
            s1_sin    <= sin_tab[hi_idx];
            s1_rad    <= RAD_W'(rad_prod >> ANG_W);
         end
      end
   end
endmodule

// File: rtl/rot_coarse_mul.sv
module rot_coarse_mul #(
   parameter int DAT_W  = 12,
   parameter int COEF_W = 16,
   parameter int CF     = 14,
   parameter int GRD    = 2,
   parameter int MID_W  = 15,
   parameter int RAD_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     s1_vld,
   input  logic signed [DAT_W-1:0]  s1_vec [2],
   input  logic signed [COEF_W-1:0] s1_cos,
   input  logic signed [COEF_W-1:0] s1_sin,
   input  logic [RAD_W-1:0]         s1_rad,
   output logic                     s2_vld,
   output logic signed [MID_W-1:0]  s2_vec [2],
   output logic [RAD_W-1:0]         s2_rad
);
   localparam int PW = DAT_W + COEF_W + 1;
   localparam int SH = CF - GRD;

   logic signed [MID_W-1:0] nxt [2];

   // lane 0: I*c - Q*s ; lane 1: Q*c + I*s
   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic signed [PW-1:0] acc;
      if (l == 0) begin : g_sub
         assign acc = PW'(s1_vec[0]) * PW'(s1_cos) - PW'(s1_vec[1]) * PW'(s1_sin)
                    + (PW'(1) <<< (SH - 1));
      end else begin : g_add
         assign acc = PW'(s1_vec[1]) * PW'(s1_cos) + PW'(s1_vec[0]) * PW'(s1_sin)
                    + (PW'(1) <<< (SH - 1));
      end
      assign nxt[l] = MID_W'(acc >>> SH);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_vld    <= 1'b0;
         s2_vec[0] <= '0;
         s2_vec[1] <= '0;
         s2_rad    <= '0;
      end else begin
         s2_vld <= s1_vld;
         if (s1_vld) begin
            s2_vec[0] <= nxt[0];
            s2_vec[1] <= nxt[1];
            s2_rad    <= s1_rad;
         end
      end
   end
endmodule

// File: rtl/rot_fine_adj.sv
module rot_fine_adj #(
   parameter int DAT_W = 12,
   parameter int MID_W = 15,
   parameter int GRD   = 2,
   parameter int RF    = 16,
   parameter int RAD_W = 14
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    s2_vld,
   input  logic signed [MID_W-1:0] s2_vec [2],
   input  logic [RAD_W-1:0]        s2_rad,
   output logic                    out_vld,
   output logic signed [DAT_W-1:0] out_vec [2]
);
   localparam int PW = MID_W + RAD_W + 2;
   localparam int SW = MID_W + 1;
   localparam int RW = SW - GRD;
   localparam logic signed [RW-1:0] TOP = RW'((1 <<< (DAT_W - 1)) - 1);
   localparam logic signed [RW-1:0] BOT = -TOP - RW'(1);

   logic signed [RAD_W:0]   rad_s;
   logic signed [DAT_W-1:0] nxt [2];

   assign rad_s = {1'b0, s2_rad};

   // lane 0: In - Qn*t ; lane 1: Qn + In*t
   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic signed [PW-1:0]    tilt;
      logic signed [MID_W-1:0] corr;
      logic signed [SW-1:0]    sum;
      logic signed [RW-1:0]    rnd;
      logic signed [DAT_W-1:0] sat;

      assign tilt = PW'(s2_vec[1-l]) * PW'(rad_s) + (PW'(1) <<< (RF - 1));
      assign corr = MID_W'(tilt >>> RF);
      if (l == 0) begin : g_sub
         assign sum = SW'(s2_vec[0]) - SW'(corr) + (SW'(1) <<< (GRD - 1));
      end else begin : g_add
         assign sum = SW'(s2_vec[1]) + SW'(corr) + (SW'(1) <<< (GRD - 1));
      end
      assign rnd = RW'(sum >>> GRD);

      always_comb begin
         if (rnd > TOP)      sat = DAT_W'(TOP);
         else if (rnd < BOT) sat = DAT_W'(BOT);
         else                sat = DAT_W'(rnd);
      end
      assign nxt[l] = sat;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld    <= 1'b0;
         out_vec[0] <= '0;
         out_vec[1] <= '0;
      end else begin
         out_vld <= s2_vld;
         if (s2_vld) begin
            out_vec[0] <= nxt[0];
            out_vec[1] <= nxt[1];
         end
      end
   end
endmodule

// File: rtl/rot_cf_top.sv
module rot_cf_top #(
   parameter int ANG_W = 12,
   parameter int HI_W  = 6,
   parameter int DAT_W = 12,
   parameter int CF    = 14,
   parameter int GRD   = 2,
   parameter int RF    = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_vld,
   input  logic [ANG_W-1:0]        in_ang,
   input  logic signed [DAT_W-1:0] in_i,
   input  logic signed [DAT_W-1:0] in_q,
   output logic                    out_vld,
   output logic signed [DAT_W-1:0] out_i,
   output logic signed [DAT_W-1:0] out_q
);
   localparam int COEF_W = CF + 2;
   localparam int MID_W  = DAT_W + 1 + GRD;
   localparam int RAD_W  = RF + 4 - HI_W;

   if (HI_W < 2 || HI_W > 8 || HI_W >= ANG_W) begin : g_bad_hi
      $error("rot_cf_top: coarse field width must be 2..8 and narrower than the angle");
   end
   if (GRD < 1 || CF <= GRD) begin : g_bad_grd
      $error("rot_cf_top: need at least one guard bit and more coefficient bits than guard bits");
   end
   if (RF < HI_W || DAT_W < 4) begin : g_bad_misc
      $error("rot_cf_top: residual fraction or data width too small");
   end

   logic                    s1_vld;
   logic signed [DAT_W-1:0] s1_vec [2];
   logic signed [COEF_W-1:0] s1_cos;
   logic signed [COEF_W-1:0] s1_sin;
   logic [RAD_W-1:0]        s1_rad;
   logic                    s2_vld;
   logic signed [MID_W-1:0] s2_vec [2];
   logic [RAD_W-1:0]        s2_rad;
   logic signed [DAT_W-1:0] res_vec [2];

   rot_coarse_lut #(
      .ANG_W(ANG_W), .HI_W(HI_W), .DAT_W(DAT_W), .CF(CF),
      .COEF_W(COEF_W), .RF(RF), .RAD_W(RAD_W)
   ) lut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_ang(in_ang),
      .in_i(in_i), .in_q(in_q), .s1_vld(s1_vld), .s1_vec(s1_vec),
      .s1_cos(s1_cos), .s1_sin(s1_sin), .s1_rad(s1_rad)
   );

   rot_coarse_mul #(
      .DAT_W(DAT_W), .COEF_W(COEF_W), .CF(CF), .GRD(GRD),
      .MID_W(MID_W), .RAD_W(RAD_W)
   ) mul_i (
      .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_vec(s1_vec),
      .s1_cos(s1_cos), .s1_sin(s1_sin), .s1_rad(s1_rad),
      .s2_vld(s2_vld), .s2_vec(s2_vec), .s2_rad(s2_rad)
   );

   rot_fine_adj #(
      .DAT_W(DAT_W), .MID_W(MID_W), .GRD(GRD), .RF(RF), .RAD_W(RAD_W)
   ) fine_i (
      .clk(clk), .rst(rst), .s2_vld(s2_vld), .s2_vec(s2_vec),
      .s2_rad(s2_rad), .out_vld(out_vld), .out_vec(res_vec)
   );

   assign out_i = res_vec[0];
   assign out_q = res_vec[1];
endmodule

// File: rtl/rot_cf_chk.sv
module rot_cf_chk #(
   parameter int ANG_W = 12,
   parameter int DAT_W = 12
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_vld,
   input logic [ANG_W-1:0]        in_ang,
   input logic signed [DAT_W-1:0] in_i,
   input logic signed [DAT_W-1:0] in_q,
   input logic                    out_vld,
   input logic signed [DAT_W-1:0] out_i,
   input logic signed [DAT_W-1:0] out_q
);
   localparam logic [ANG_W-1:0]        QTR  = ANG_W'(1) << (ANG_W - 2);
   localparam logic signed [DAT_W-1:0] MINV = {1'b1, {(DAT_W-1){1'b0}}};

   // edges seen since reset, saturating at the pipeline depth
   logic [1:0] since_rst;
   logic       warm;

   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end
   assign warm = (since_rst == 2'd3);

   p_reset_quiet_r2: assert property (@(posedge clk) rst |=> !out_vld);

   p_latency_r1: assert property (@(posedge clk) disable iff (rst)
      warm |-> (out_vld == $past(in_vld, 3)));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (warm && !out_vld) |-> ($stable(out_i) && $stable(out_q)));

   p_zero_angle_r5: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld && $past(in_ang, 3) == '0)
      |-> (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

   p_quarter_turn_r9: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld && $past(in_ang, 3) == QTR && $past(in_q, 3) != MINV)
      |-> (out_i == -$past(in_q, 3) && out_q == $past(in_i, 3)));
endmodule

bind rot_cf_top rot_cf_chk #(.ANG_W(ANG_W), .DAT_W(DAT_W)) chk_i (
   .clk(clk), .rst(rst), .in_vld(in_vld), .in_ang(in_ang),
   .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
);

// File: tb/rot_cf_top_tb_top.sv
module rot_cf_top_tb_top;
   localparam int ANG_W = 12;
   localparam int HI_W  = 6;
   localparam int DAT_W = 12;
   localparam int NV    = 12;
   localparam real TWO_PI = 6.283185307179586;

   typedef struct packed {
      int ang;
      int vi;
      int vq;
      int ei;
      int eq;
      int tol;
      bit mdl;
   } vec_t;

   // stimulus with expected result; mdl=1 means expected comes from the real model
   localparam vec_t TBL [NV] = '{
      '{0,    1000,  -500,  1000, -500, 0, 1'b0},
      '{1024, 700,   300,   -300, 700,  0, 1'b0},
      '{2048, -2048, 5,     2047, -5,   0, 1'b0},
      '{3072, 123,   -456,  -456, -123, 0, 1'b0},
      '{512,  2047,  2047,  0,    0,    2, 1'b1},
      '{357,  1500,  -800,  0,    0,    2, 1'b1},
      '{63,   2000,  0,     0,    0,    2, 1'b1},
      '{4095, -1200, 1700,  0,    0,    2, 1'b1},
      '{1000, -2048, -2048, 0,    0,    2, 1'b1},
      '{2731, 333,   1999,  0,    0,    2, 1'b1},
      '{1536, 1024,  0,     0,    0,    1, 1'b1},
      '{192,  -700,  1800,  0,    0,    1, 1'b1}
   };

   logic                    clk = 1'b0;
   logic                    rst;
   logic                    in_vld;
   logic [ANG_W-1:0]        in_ang;
   logic signed [DAT_W-1:0] in_i;
   logic signed [DAT_W-1:0] in_q;
   logic                    out_vld;
   logic signed [DAT_W-1:0] out_i;
   logic signed [DAT_W-1:0] out_q;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;

   always #4ns clk = ~clk;

   rot_cf_top #(.ANG_W(ANG_W), .HI_W(HI_W), .DAT_W(DAT_W)) dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_ang(in_ang),
      .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
   );

   function automatic string tag_of(input int k);
      case (k)
         0:       return "R5";
         1, 3:    return "R9";
         2, 4, 8: return "R6";
         10, 11:  return "R3";
         default: return "R4";
      endcase
   endfunction

   // coarse exact rotation, first-order fine step, rounding and clamping
   function automatic int model_lane(input int ang, input int vi, input int vq, input bit want_q);
      int  hi;
      int  lo;
      int  v;
      int  lim;
      real ah;
      real t;
      real ci;
      real cq;
      real r;
      hi  = ang >> (ANG_W - HI_W);
      lo  = ang & ((1 << (ANG_W - HI_W)) - 1);
      ah  = TWO_PI * real'(hi) / real'(1 << HI_W);
      ci  = real'(vi) * $cos(ah) - real'(vq) * $sin(ah);
      cq  = real'(vi) * $sin(ah) + real'(vq) * $cos(ah);
      t   = TWO_PI * real'(lo) / real'(1 << ANG_W);
      r   = want_q ? (cq + ci * t) : (ci - cq * t);
      v   = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
      lim = 1 << (DAT_W - 1);
      if (v > lim - 1) v = lim - 1;
      if (v < -lim)    v = -lim;
      return v;
   endfunction

   task automatic check_val(input string req, input string what, input int act,
                            input int exp, input int tol);
      int d;
      d = act - exp;
      if (d < 0) d = -d;
      nchk++;
      if (d > tol) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d (tol %0d)", req, what, act, exp, tol);
      end
   endtask

   task automatic drive(input bit v, input int ang, input int vi, input int vq);
      in_vld = v;
      in_ang = ANG_W'(ang);
      in_i   = DAT_W'(vi);
      in_q   = DAT_W'(vq);
   endtask

   task automatic check_entry(input int k);
      int ei;
      int eq;
      ei = TBL[k].mdl ? model_lane(TBL[k].ang, TBL[k].vi, TBL[k].vq, 1'b0) : TBL[k].ei;
      eq = TBL[k].mdl ? model_lane(TBL[k].ang, TBL[k].vi, TBL[k].vq, 1'b1) : TBL[k].eq;
      check_val("R7", $sformatf("out_vld entry %0d", k), int'(out_vld), 1, 0);
      check_val(tag_of(k), $sformatf("out_i entry %0d", k), int'(out_i), ei, TBL[k].tol);
      check_val(tag_of(k), $sformatf("out_q entry %0d", k), int'(out_q), eq, TBL[k].tol);
   endtask

   initial begin
      int held_i;
      int held_q;
      rst = 1'b1;
      drive(1'b0, 0, 0, 0);
      repeat (3) @(negedge clk);
      check_val("R2", "out_vld in reset", int'(out_vld), 0, 0);
      check_val("R2", "out_i in reset", int'(out_i), 0, 0);
      check_val("R2", "out_q in reset", int'(out_q), 0, 0);
      rst = 1'b0;

      // back-to-back walk of the vector table
      for (int m = 0; m < NV + 3; m++) begin
         if (m >= 3) check_entry(m - 3);
         else check_val("R1", "out_vld before first result", int'(out_vld), 0, 0);
         if (m < NV) drive(1'b1, TBL[m].ang, TBL[m].vi, TBL[m].vq);
         else drive(1'b0, 0, 0, 0);
         @(negedge clk);
      end

      // idle inputs with changing data must not disturb held outputs
      held_i = int'(out_i);
      held_q = int'(out_q);
      for (int k = 0; k < 4; k++) begin
         drive(1'b0, 37 * k + 5, 900 - 311 * k, -77 * k);
         @(negedge clk);
         check_val("R8", "out_vld while idle", int'(out_vld), 0, 0);
         check_val("R8", "out_i held", int'(out_i), held_i, 0);
         check_val("R8", "out_q held", int'(out_q), held_q, 0);
      end

      // single sample: exact latency
      drive(1'b1, 0, 77, -33);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 1) drive(1'b0, 0, 0, 0);
         if (k == 3) begin
            check_val("R1", "out_vld at third edge", int'(out_vld), 1, 0);
            check_val("R5", "out_i identity", int'(out_i), 77, 0);
            check_val("R5", "out_q identity", int'(out_q), -33, 0);
         end else begin
            check_val("R1", $sformatf("out_vld at edge %0d", k), int'(out_vld), 0, 0);
         end
      end

      // reset while two samples are in flight
      drive(1'b1, TBL[5].ang, TBL[5].vi, TBL[5].vq);
      @(negedge clk);
      drive(1'b1, TBL[6].ang, TBL[6].vi, TBL[6].vq);
      @(negedge clk);
      rst = 1'b1;
      drive(1'b0, 0, 0, 0);
      @(negedge clk);
      check_val("R2", "out_vld after mid-flight reset", int'(out_vld), 0, 0);
      check_val("R2", "out_i after mid-flight reset", int'(out_i), 0, 0);
      check_val("R2", "out_q after mid-flight reset", int'(out_q), 0, 0);
      rst = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check_val("R2", "flushed sample stays hidden", int'(out_vld), 0, 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule